// File: doc/BRIEF.md
# Gated Pulse Timer

This block is a counter that advances by one on each timer tick, but only while a conditioned gate signal allows it. An asynchronous gate input is first brought into the block clock domain. It can then be inverted, and it can optionally be turned into a divide-by-two signal that flips on every active edge. The result is the conditioned gate value. With gating turned off, the counter simply runs on every tick.

A one-shot mode lets software capture exactly one gate pulse. Software enables the mode and then raises an armed bit. Counting opens on the next rising edge of the conditioned gate value. On the following falling edge, hardware drops the armed bit, and the counter holds until software arms the block again. When toggle mode is on as well, a single armed capture covers one full period of the gate source, from one active input edge to the next. A sticky gate-event flag records falling edges of the conditioned gate value. Software clears the flag, and a hardware set in the same cycle takes precedence over the clear.

The block moves no data stream, so it has no valid/ready interface. All pins are plain control and status levels or one-cycle strobes. Software strobes are sampled on the rising clock edge and take effect in the next cycle.

Top module: `gated_pulse_timer`

## Requirements
- R1: After reset, count_o is 0, armed_o is 0 and flag_o is 0.
- R2: When gate_en_i is 0, count_o advances by one on every clock in which tick_i is 1, whatever the gate input does.
- R3: When gate_en_i is 1 and one_shot_en_i is 0, count_o advances only on ticks while the conditioned gate value is high. A change on gate_raw_i reaches the conditioned value after two clock edges. A raw pulse lasting H cycles, with tick_i held at 1, therefore adds exactly H. Without ticks, count_o never moves.
- R4: With gate_inv_i at 1, the raw gate is active low: a low pulse of H cycles adds H, and a steady high input adds nothing.
- R5: With toggle_en_i at 1, the conditioned gate value flips on each rising edge of the polarity-adjusted input. A raw high of H cycles followed by a low of L cycles lets the count grow by H+L between two successive active edges.
- R6: With one_shot_en_i at 1, an arm_set_i strobe raises armed_o. Only the first complete pulse of the conditioned gate value after arming is counted. armed_o falls at the end of that pulse, and later pulses add nothing until the block is armed again. With toggle on as well, the counted span is one full gate-source period.
- R7: If the block is armed while the conditioned gate value is already high, that pulse is not counted and armed_o stays high. Counting starts at the next rising edge.
- R8: Driving one_shot_en_i to 0 forces armed_o to 0 by the next cycle, and arm_set_i has no effect while one_shot_en_i is 0.
- R9: An arm_clr_i strobe drops armed_o, and a pulse that follows is not counted.
- R10: flag_o is set on a falling edge of the conditioned gate value while gate_en_i is 1. In one-shot mode it is set only at the falling edge that ends an armed capture. It is never set while gate_en_i is 0. flag_clr_i clears it, except in a cycle where a set occurs, in which case flag_o stays 1.
- R11: A cnt_wr_i strobe loads cnt_wr_data_i into count_o and takes priority over a tick in the same cycle. The counter wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick, one increment opportunity per cycle |
| gate_raw_i | input | 1 | Asynchronous gate input |
| gate_en_i | input | 1 | 1: count only while the gate allows; 0: count every tick |
| gate_inv_i | input | 1 | 1: raw gate is active low |
| toggle_en_i | input | 1 | 1: conditioned gate flips on each active edge |
| one_shot_en_i | input | 1 | 1: enable armed single-pulse capture |
| arm_set_i | input | 1 | Strobe: arm a capture |
| arm_clr_i | input | 1 | Strobe: disarm |
| flag_clr_i | input | 1 | Strobe: clear the gate-event flag |
| cnt_wr_i | input | 1 | Strobe: load the counter |
| cnt_wr_data_i | input | CNT_W | Value to load |
| count_o | output | CNT_W | Counter value |
| armed_o | output | 1 | Capture armed (go/done readback) |
| gate_val_o | output | 1 | Conditioned gate value |
| flag_o | output | 1 | Sticky gate-event flag |

## Verification
A wrong arm state shows at the pins in one of two ways: armed_o fails to fall within three cycles of the raw gate's trailing edge, or count_o ends a capture off by exactly the length of a pulse that should not have counted. A broken synchronizer or toggle stage shows as a count that is off by one or more from the raw pulse length or the raw period. A wrong flag priority shows as flag_o being low one cycle after a clear that coincides with a falling edge. Every such fault becomes visible within a few cycles of the gate edge that exposes it.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_WAIT = 2'd1,
    ARM_OPEN = 2'd2
  } arm_state_t;
endpackage

// File: rtl/gpt_gate_cond.sv
module gpt_gate_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_raw_i,
  input  logic gate_inv_i,
  input  logic toggle_en_i,
  output logic gval_o,
  output logic gval_rise_o,
  output logic gval_fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic pol, pol_q, pol_rise;
  logic tog_q;
  logic gval, gval_q;

  // synchronizer chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= gate_raw_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign pol      = sync_q[LAST] ^ gate_inv_i;
  assign pol_rise = pol & ~pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      pol_q <= pol;
      if (!toggle_en_i)  tog_q <= 1'b0;
      else if (pol_rise) tog_q <= ~tog_q;
    end
  end

  assign gval = toggle_en_i ? tog_q : pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gval_q <= 1'b0;
    else        gval_q <= gval;
  end

  assign gval_o      = gval;
  assign gval_rise_o = gval & ~gval_q;
  assign gval_fall_o = ~gval & gval_q;
endmodule

// File: rtl/gpt_arm_fsm.sv
module gpt_arm_fsm
  import gpt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic one_shot_en_i,
  input  logic arm_set_i,
  input  logic arm_clr_i,
  input  logic gval_rise_i,
  input  logic gval_fall_i,
  output logic armed_o,
  output logic window_o,
  output logic done_o
);
  arm_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!one_shot_en_i || arm_clr_i) begin
      state_d = ARM_IDLE;
    end else begin
      unique case (state_q)
        ARM_IDLE: if (arm_set_i)   state_d = ARM_WAIT;
        ARM_WAIT: if (gval_rise_i) state_d = ARM_OPEN;
        ARM_OPEN: if (gval_fall_i) state_d = ARM_IDLE;
        default:                   state_d = ARM_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARM_IDLE;
    else        state_q <= state_d;
  end

  assign armed_o  = (state_q != ARM_IDLE);
  // the rising-edge cycle itself already belongs to the captured pulse
  assign window_o = (state_q == ARM_OPEN) | ((state_q == ARM_WAIT) & gval_rise_i);
  assign done_o   = (state_q == ARM_OPEN) & gval_fall_i;
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cnt_en_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wr_data_i,
  input  logic             flag_set_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (cnt_wr_i)            cnt_q <= cnt_wr_data_i;
    else if (tick_i && cnt_en_i)  cnt_q <= cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (flag_set_i) flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign count_o = cnt_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/gated_pulse_timer.sv
module gated_pulse_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             gate_raw_i,
  input  logic             gate_en_i,
  input  logic             gate_inv_i,
  input  logic             toggle_en_i,
  input  logic             one_shot_en_i,
  input  logic             arm_set_i,
  input  logic             arm_clr_i,
  input  logic             flag_clr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             armed_o,
  output logic             gate_val_o,
  output logic             flag_o
);
  logic gval, gval_rise, gval_fall;
  logic window, done;
  logic cnt_en, flag_set;

  gpt_gate_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_raw_i  (gate_raw_i),
    .gate_inv_i  (gate_inv_i),
    .toggle_en_i (toggle_en_i),
    .gval_o      (gval),
    .gval_rise_o (gval_rise),
    .gval_fall_o (gval_fall)
  );

  gpt_arm_fsm u_arm (
    .clk           (clk),
    .rst_n         (rst_n),
    .one_shot_en_i (one_shot_en_i),
    .arm_set_i     (arm_set_i),
    .arm_clr_i     (arm_clr_i),
    .gval_rise_i   (gval_rise),
    .gval_fall_i   (gval_fall),
    .armed_o       (armed_o),
    .window_o      (window),
    .done_o        (done)
  );

  // ungated when gating is off; otherwise gate level, qualified by the capture window
  assign cnt_en   = ~gate_en_i | (gval & (~one_shot_en_i | window));
  assign flag_set = gate_en_i & (one_shot_en_i ? done : gval_fall);

  gpt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .cnt_en_i      (cnt_en),
    .cnt_wr_i      (cnt_wr_i),
    .cnt_wr_data_i (cnt_wr_data_i),
    .flag_set_i    (flag_set),
    .flag_clr_i    (flag_clr_i),
    .count_o       (count_o),
    .flag_o        (flag_o)
  );

  assign gate_val_o = gval;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             gate_en_i,
  input logic             one_shot_en_i,
  input logic             arm_set_i,
  input logic             flag_clr_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wr_data_i,
  input logic [CNT_W-1:0] count_o,
  input logic             armed_o,
  input logic             flag_o
);
  assert_ungated_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_en_i && tick_i && !cnt_wr_i) |=> count_o == CNT_W'($past(count_o) + 1'b1));

  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr_i) |=> $stable(count_o));

  assert_idle_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_i && one_shot_en_i && !armed_o && !cnt_wr_i) |=> $stable(count_o));

  assert_arm_needs_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> $past(arm_set_i));

  assert_disable_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !one_shot_en_i |=> !armed_o);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

  assert_write_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> count_o == $past(cnt_wr_data_i));
endmodule

bind gated_pulse_timer gpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .gate_en_i     (gate_en_i),
  .one_shot_en_i (one_shot_en_i),
  .arm_set_i     (arm_set_i),
  .flag_clr_i    (flag_clr_i),
  .cnt_wr_i      (cnt_wr_i),
  .cnt_wr_data_i (cnt_wr_data_i),
  .count_o       (count_o),
  .armed_o       (armed_o),
  .flag_o        (flag_o)
);

// File: tb/sim_gated_pulse_timer.sv
`timescale 1ns/1ps
module sim_gated_pulse_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0, gate_raw_i = 1'b0, gate_en_i = 1'b0, gate_inv_i = 1'b0;
  logic toggle_en_i = 1'b0, one_shot_en_i = 1'b0, arm_set_i = 1'b0, arm_clr_i = 1'b0;
  logic flag_clr_i = 1'b0, cnt_wr_i = 1'b0;
  logic [W-1:0] cnt_wr_data_i = '0;
  logic [W-1:0] count_o;
  logic armed_o, gate_val_o, flag_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gated_pulse_timer #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_raw_i(gate_raw_i),
    .gate_en_i(gate_en_i), .gate_inv_i(gate_inv_i), .toggle_en_i(toggle_en_i),
    .one_shot_en_i(one_shot_en_i), .arm_set_i(arm_set_i), .arm_clr_i(arm_clr_i),
    .flag_clr_i(flag_clr_i), .cnt_wr_i(cnt_wr_i), .cnt_wr_data_i(cnt_wr_data_i),
    .count_o(count_o), .armed_o(armed_o), .gate_val_o(gate_val_o), .flag_o(flag_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // wait for the gate path to settle, then zero the counter and flag
  task automatic settle();
    cycles(6);
    cnt_wr_i = 1'b1; cnt_wr_data_i = '0; flag_clr_i = 1'b1;
    @(negedge clk);
    cnt_wr_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  task automatic pulse(input int h, input int l);
    gate_raw_i = ~gate_inv_i;
    cycles(h);
    gate_raw_i = gate_inv_i;
    cycles(l);
  endtask

  task automatic arm();
    arm_set_i = 1'b1;
    @(negedge clk);
    arm_set_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cycles(4);
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 armed", int'(armed_o), 0);
    chk("R1 flag", int'(flag_o), 0);
    rst_n = 1'b1;
    cycles(2);

    // R2 ungated counting, gate wiggling
    for (int n = 1; n <= 10; n++) begin
      settle();
      tick_i = 1'b1;
      for (int i = 0; i < n; i++) begin gate_raw_i = ~gate_raw_i; @(negedge clk); end
      tick_i = 1'b0;
      chk("R2 ungated", int'(count_o), n);
    end

    // R3 gated by pulse length
    gate_en_i = 1'b1; gate_raw_i = 1'b0; tick_i = 1'b1;
    for (int h = 1; h <= 8; h++) begin
      settle();
      pulse(h, 5);
      chk("R3 pulse count", int'(count_o), h);
      chk("R10 flag on fall", int'(flag_o), 1);
    end
    // R3 two-edge latency
    settle();
    gate_raw_i = 1'b1;
    cycles(2);
    chk("R3 latency early", int'(count_o), 0);
    @(negedge clk);
    chk("R3 latency first", int'(count_o), 1);
    gate_raw_i = 1'b0;
    cycles(5);
    // R3 no tick
    tick_i = 1'b0;
    settle();
    pulse(4, 5);
    chk("R3 no tick", int'(count_o), 0);
    tick_i = 1'b1;

    // R4 inverted polarity
    gate_inv_i = 1'b1; gate_raw_i = 1'b1;
    for (int h = 1; h <= 6; h++) begin
      settle();
      pulse(h, 5);
      chk("R4 low pulse", int'(count_o), h);
    end
    settle();
    cycles(10);
    chk("R4 idle high", int'(count_o), 0);
    gate_inv_i = 1'b0; gate_raw_i = 1'b0;
    settle();

    // R5 toggle: count spans H+L
    toggle_en_i = 1'b1;
    settle();
    for (int h = 1; h <= 4; h++) begin
      for (int l = 2; l <= 5; l++) begin
        settle();
        pulse(h, l);
        pulse(1, 6);
        chk("R5 period", int'(count_o), h + l);
      end
    end
    toggle_en_i = 1'b0;
    settle();

    // R6 one-shot single pulse
    one_shot_en_i = 1'b1;
    settle();
    pulse(5, 4);
    chk("R6 unarmed", int'(count_o), 0);
    chk("R10 unarmed flag", int'(flag_o), 0);
    for (int h = 1; h <= 6; h++) begin
      settle();
      arm();
      chk("R6 armed", int'(armed_o), 1);
      pulse(h, 4);
      pulse(3, 4);
      chk("R6 one pulse", int'(count_o), h);
      chk("R6 done", int'(armed_o), 0);
      chk("R10 end flag", int'(flag_o), 1);
    end

    // R7 armed mid-pulse
    settle();
    gate_raw_i = 1'b1;
    cycles(5);
    arm();
    cycles(3);
    gate_raw_i = 1'b0;
    cycles(4);
    chk("R7 skipped", int'(count_o), 0);
    chk("R7 still armed", int'(armed_o), 1);
    pulse(4, 4);
    chk("R7 next pulse", int'(count_o), 4);
    chk("R7 done", int'(armed_o), 0);

    // R8 disable disarms; arm ignored while disabled
    settle();
    arm();
    one_shot_en_i = 1'b0;
    @(negedge clk);
    chk("R8 forced clear", int'(armed_o), 0);
    arm();
    one_shot_en_i = 1'b1;
    @(negedge clk);
    chk("R8 arm ignored", int'(armed_o), 0);

    // R9 software disarm
    settle();
    arm();
    arm_clr_i = 1'b1;
    @(negedge clk);
    arm_clr_i = 1'b0;
    chk("R9 disarmed", int'(armed_o), 0);
    pulse(3, 4);
    chk("R9 no count", int'(count_o), 0);

    // R6 with toggle: one full period
    toggle_en_i = 1'b1;
    settle();
    arm();
    pulse(3, 5);
    pulse(2, 6);
    pulse(2, 6);
    chk("R6 toggle period", int'(count_o), 8);
    chk("R6 toggle done", int'(armed_o), 0);
    toggle_en_i = 1'b0;
    one_shot_en_i = 1'b0;
    settle();

    // R10 set wins over clear
    pulse(3, 4);
    chk("R10 set", int'(flag_o), 1);
    gate_raw_i = 1'b1;
    cycles(4);
    gate_raw_i = 1'b0;
    cycles(2);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    chk("R10 set wins", int'(flag_o), 1);
    flag_clr_i = 1'b1;
    @(negedge clk);
    flag_clr_i = 1'b0;
    chk("R10 clear", int'(flag_o), 0);
    gate_en_i = 1'b0;
    settle();
    pulse(3, 4);
    chk("R10 ungated no flag", int'(flag_o), 0);

    // R11 write, priority and wrap
    tick_i = 1'b0;
    cnt_wr_i = 1'b1; cnt_wr_data_i = 16'hFFFF;
    @(negedge clk);
    cnt_wr_i = 1'b0;
    chk("R11 load", int'(count_o), 16'hFFFF);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    chk("R11 wrap", int'(count_o), 0);
    tick_i = 1'b1; cnt_wr_i = 1'b1; cnt_wr_data_i = 16'h1234;
    @(negedge clk);
    cnt_wr_i = 1'b0;
    chk("R11 priority", int'(count_o), 16'h1234);
    @(negedge clk);
    tick_i = 1'b0;
    chk("R11 resume", int'(count_o), 16'h1235);

    finish_run();
  end
endmodule